// File: doc/BRIEF.md
# GPIO Edge Interrupt Controller

This block watches a bank of general-purpose pins and turns chosen signal edges into one interrupt request. Each pin goes through a two-flop synchronizer and an edge detector. Software picks rising or falling detection for each pin. A pin can latch a status bit only while it is an input and is not masked. Status bits stay set until software writes a 1 to clear them. The interrupt output is high while any latched status bit belongs to an unmasked pin and the GPIO group is routed to interrupt output 0.

Software reaches the block through a simple 32-bit register port. Write strobe, address and write data are sampled on a rising clock edge. Read data is combinational from the current address. The mask has no plain read-modify-write register. It changes only through a write-ones-to-set address and a write-ones-to-clear address. Either address reads back the current mask. Pad drivers and the host bus bridge sit outside this block. The block drives only an output-enable vector derived from the direction setting.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: While reset is asserted, and until the first register write after it, the registers read as follows: direction 0xFFFF (all inputs), mask 0xFFFF (all masked), edge select 0, status 0, routing 0. `irq0_o` is 0 and `pin_oe_o` is 0.
- R2: A write to 0xA1C sets every mask bit whose write-data bit is 1. Bits written as 0 and write-data bits 31:16 leave the mask unchanged. The mask reads back at 0xA1C and at 0xA18.
- R3: A write to 0xA18 clears every mask bit whose write-data bit is 1. Bits written as 0 leave the mask unchanged.
- R4: The edge-select register at 0xA28 reads back as written. A 1 in bit n selects rising-edge detection for pin n. A 0 selects falling-edge detection. The opposite edge never sets status.
- R5: A selected edge on an unmasked input pin sets its status bit (register 0xA20, bit n = pin n). A pin change driven between two clock edges is visible in status after the third following rising edge and not after the second. A level held for two or more cycles is always detected.
- R6: Status bits are sticky. A write to 0xA20 clears exactly the bits written as 1. Bits written as 0 stay as they are.
- R7: If a selected edge and a write-one-to-clear of the same status bit fall in the same cycle, the bit ends up set.
- R8: The routing register at 0x820 holds only bit 15. All its other bits read 0. `irq0_o` is 1 exactly when routing bit 15 is 1 and at least one status bit is set for an unmasked pin.
- R9: The direction register at 0xA04 reads back as written. A 1 makes pin n an input. `pin_oe_o[n]` is the inverse of direction bit n. Edges on pins set as outputs never set status.
- R10: Reads of any address outside the six mapped registers return 0. Writes to such addresses change nothing.
- R11: Edges on a masked pin do not set status. Masking a pin whose status is already set keeps the status bit but removes it from `irq0_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 12 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| pin_i | input | 16 | Asynchronous pin levels |
| pin_oe_o | output | 16 | Output enable per pin (1 = pin driven as output) |
| irq0_o | output | 1 | Interrupt output 0 |

## Verification
The collision of interest is a status bit being set by a fresh edge in the same cycle that software write-one-clears that same bit. The bench first latches the bit with an earlier edge and returns the pin to its idle level. It then raises the pin again and issues the clearing write so that its sampling edge is the third rising edge after the pin change. That is the same edge on which the synchronized edge reaches status. The status register must still read the bit as set afterwards. A following clearing write with no edge pending must leave it at 0, which shows the write itself was effective.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  localparam int unsigned REG_ADDR_W = 12;

  localparam logic [REG_ADDR_W-1:0] OFS_ROUTE = 12'h820;
  localparam logic [REG_ADDR_W-1:0] OFS_DIR   = 12'hA04;
  localparam logic [REG_ADDR_W-1:0] OFS_MCLR  = 12'hA18;
  localparam logic [REG_ADDR_W-1:0] OFS_MSET  = 12'hA1C;
  localparam logic [REG_ADDR_W-1:0] OFS_STAT  = 12'hA20;
  localparam logic [REG_ADDR_W-1:0] OFS_EDGE  = 12'hA28;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_MCLR,
    SEL_MSET,
    SEL_STAT,
    SEL_EDGE,
    SEL_ROUTE
  } reg_sel_e;

  function automatic reg_sel_e decode_sel(input logic [REG_ADDR_W-1:0] addr);
    reg_sel_e sel;
    case (addr)
      OFS_DIR:   sel = SEL_DIR;
      OFS_MCLR:  sel = SEL_MCLR;
      OFS_MSET:  sel = SEL_MSET;
      OFS_STAT:  sel = SEL_STAT;
      OFS_EDGE:  sel = SEL_EDGE;
      OFS_ROUTE: sel = SEL_ROUTE;
      default:   sel = SEL_NONE;
    endcase
    return sel;
  endfunction

endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  logic [STAGES-1:0][WIDTH-1:0] stage_q;
  logic [STAGES-1:0][WIDTH-1:0] stage_d;

  always_comb begin
    stage_d[0] = d_i;
    for (int i = 1; i < STAGES; i++) begin
      stage_d[i] = stage_q[i-1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] level_i,
  input  logic [NUM_PINS-1:0] rise_sel_i,
  input  logic [NUM_PINS-1:0] arm_i,
  output logic [NUM_PINS-1:0] event_o
);

  logic [NUM_PINS-1:0] prev_q;
  logic [NUM_PINS-1:0] prev_d;

  assign prev_d = level_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= '0;
    end else begin
      prev_q <= prev_d;
    end
  end

  for (genvar b = 0; b < NUM_PINS; b++) begin : g_bit
    logic went_up;
    logic went_down;
    assign went_up    = level_i[b] & ~prev_q[b];
    assign went_down  = ~level_i[b] & prev_q[b];
    assign event_o[b] = arm_i[b] & (rise_sel_i[b] ? went_up : went_down);
  end

endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 16,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned ROUTE_BIT = 15
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [REG_ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0]     wdata_i,
  input  logic [NUM_PINS-1:0]   status_i,
  output logic [DATA_W-1:0]     rdata_o,
  output logic [NUM_PINS-1:0]   dir_o,
  output logic [NUM_PINS-1:0]   mask_o,
  output logic [NUM_PINS-1:0]   rise_o,
  output logic                  route_o,
  output logic [NUM_PINS-1:0]   stat_clr_o
);

  localparam int unsigned PAD_W = DATA_W - NUM_PINS;

  reg_sel_e            sel;
  logic [NUM_PINS-1:0] wr_bits;
  logic                unused_hi;

  logic [NUM_PINS-1:0] dir_q,  dir_d;
  logic [NUM_PINS-1:0] mask_q, mask_d;
  logic [NUM_PINS-1:0] rise_q, rise_d;
  logic                route_q, route_d;
  logic                dir_en, mask_en, rise_en, route_en;

  assign sel       = decode_sel(addr_i);
  assign wr_bits   = wdata_i[NUM_PINS-1:0];
  assign unused_hi = ^wdata_i[DATA_W-1:NUM_PINS];

  // Write enables and next values
  always_comb begin
    dir_en   = we_i && (sel == SEL_DIR);
    rise_en  = we_i && (sel == SEL_EDGE);
    route_en = we_i && (sel == SEL_ROUTE);
    mask_en  = we_i && ((sel == SEL_MSET) || (sel == SEL_MCLR));

    dir_d    = wr_bits;
    rise_d   = wr_bits;
    route_d  = wdata_i[ROUTE_BIT];
    if (sel == SEL_MSET) begin
      mask_d = mask_q | wr_bits;
    end else begin
      mask_d = mask_q & ~wr_bits;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '1;
      mask_q  <= '1;
      rise_q  <= '0;
      route_q <= 1'b0;
    end else begin
      if (dir_en) begin
        dir_q <= dir_d;
      end
      if (mask_en) begin
        mask_q <= mask_d;
      end
      if (rise_en) begin
        rise_q <= rise_d;
      end
      if (route_en) begin
        route_q <= route_d;
      end
    end
  end

  // Status clear strobe toward the status bank
  always_comb begin
    if (we_i && (sel == SEL_STAT)) begin
      stat_clr_o = wr_bits;
    end else begin
      stat_clr_o = '0;
    end
  end

  // Read multiplexer
  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_DIR:             rdata_o = {{PAD_W{1'b0}}, dir_q};
      SEL_MSET, SEL_MCLR:  rdata_o = {{PAD_W{1'b0}}, mask_q};
      SEL_STAT:            rdata_o = {{PAD_W{1'b0}}, status_i};
      SEL_EDGE:            rdata_o = {{PAD_W{1'b0}}, rise_q};
      SEL_ROUTE:           rdata_o[ROUTE_BIT] = route_q;
      default:             rdata_o = '0;
    endcase
  end

  assign dir_o   = dir_q;
  assign mask_o  = mask_q;
  assign rise_o  = rise_q;
  assign route_o = route_q;

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int unsigned NUM_PINS = 16
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_PINS-1:0] event_i,
  input  logic [NUM_PINS-1:0] clr_i,
  input  logic [NUM_PINS-1:0] mask_i,
  input  logic                route_i,
  output logic [NUM_PINS-1:0] status_o,
  output logic                irq_o
);

  logic [NUM_PINS-1:0] stat_q, stat_d;
  logic                stat_en;

  // A new event takes priority over a clear of the same bit
  always_comb begin
    stat_en = (|event_i) || (|clr_i);
    stat_d  = (stat_q & ~clr_i) | event_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
    end else if (stat_en) begin
      stat_q <= stat_d;
    end
  end

  assign status_o = stat_q;
  assign irq_o    = route_i & (|(stat_q & ~mask_i));

endmodule

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS    = 16,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned ROUTE_BIT   = 15,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  input  logic                  reg_we_i,
  input  logic [REG_ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0]     reg_wdata_i,
  output logic [DATA_W-1:0]     reg_rdata_o,
  input  logic [NUM_PINS-1:0]   pin_i,
  output logic [NUM_PINS-1:0]   pin_oe_o,
  output logic                  irq0_o
);

  logic rst_meta_q, rst_q_n;

  // Reset asserts at once, releases on a clock edge
  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      rst_meta_q <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_q_n    <= rst_meta_q;
    end
  end

  logic [NUM_PINS-1:0] level_sync;
  logic [NUM_PINS-1:0] dir_q, mask_q, rise_q, status_q, stat_clr, edge_evt, arm;
  logic                route_q;

  gpio_irq_sync #(
    .WIDTH  (NUM_PINS),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_q_n),
    .d_i    (pin_i),
    .q_o    (level_sync)
  );

  gpio_irq_regs #(
    .NUM_PINS  (NUM_PINS),
    .DATA_W    (DATA_W),
    .ROUTE_BIT (ROUTE_BIT)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_q_n),
    .we_i       (reg_we_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .status_i   (status_q),
    .rdata_o    (reg_rdata_o),
    .dir_o      (dir_q),
    .mask_o     (mask_q),
    .rise_o     (rise_q),
    .route_o    (route_q),
    .stat_clr_o (stat_clr)
  );

  assign arm = dir_q & ~mask_q;

  gpio_irq_edge #(
    .NUM_PINS (NUM_PINS)
  ) u_edge (
    .clk_i      (clk_i),
    .rst_ni     (rst_q_n),
    .level_i    (level_sync),
    .rise_sel_i (rise_q),
    .arm_i      (arm),
    .event_o    (edge_evt)
  );

  gpio_irq_status #(
    .NUM_PINS (NUM_PINS)
  ) u_status (
    .clk_i    (clk_i),
    .rst_ni   (rst_q_n),
    .event_i  (edge_evt),
    .clr_i    (stat_clr),
    .mask_i   (mask_q),
    .route_i  (route_q),
    .status_o (status_q),
    .irq_o    (irq0_o)
  );

  assign pin_oe_o = ~dir_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
module gpio_irq_ctrl_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_PINS = 16,
  parameter int unsigned DATA_W   = 32
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  we_i,
  input logic [REG_ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0]     wdata_i,
  input logic [NUM_PINS-1:0]   mask_i,
  input logic [NUM_PINS-1:0]   dir_i,
  input logic [NUM_PINS-1:0]   status_i,
  input logic                  route_i,
  input logic                  irq_i
);

  a_r2_mask_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_MSET) |=>
      ((mask_i & $past(wdata_i[NUM_PINS-1:0])) == $past(wdata_i[NUM_PINS-1:0])));

  a_r3_mask_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && addr_i == OFS_MCLR) |=>
      ((mask_i & $past(wdata_i[NUM_PINS-1:0])) == '0));

  a_r6_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(we_i && addr_i == OFS_STAT) |=>
      ((status_i & $past(status_i)) == $past(status_i)));

  a_r11_masked_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & ~$past(status_i) & $past(mask_i)) == '0));

  a_r9_output_no_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((status_i & ~$past(status_i) & ~$past(dir_i)) == '0));

  a_r8_irq_needs_route: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> route_i);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(
  .NUM_PINS (NUM_PINS),
  .DATA_W   (DATA_W)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_q_n),
  .we_i     (reg_we_i),
  .addr_i   (reg_addr_i),
  .wdata_i  (reg_wdata_i),
  .mask_i   (mask_q),
  .dir_i    (dir_q),
  .status_i (status_q),
  .route_i  (route_q),
  .irq_i    (irq0_o)
);

// File: tb/gpio_irq_ctrl_test.sv
module gpio_irq_ctrl_test;

  localparam logic [11:0] A_ROUTE = 12'h820;
  localparam logic [11:0] A_DIR   = 12'hA04;
  localparam logic [11:0] A_MCLR  = 12'hA18;
  localparam logic [11:0] A_MSET  = 12'hA1C;
  localparam logic [11:0] A_STAT  = 12'hA20;
  localparam logic [11:0] A_EDGE  = 12'hA28;
  localparam logic [11:0] A_HOLE  = 12'h100;

  typedef struct packed {
    logic [11:0] waddr;
    logic [31:0] wdata;
    logic [11:0] raddr;
    logic [31:0] expect_val;
    logic [7:0]  req;
  } vec_t;

  localparam int NVEC = 12;
  localparam vec_t VECS [NVEC] = '{
    '{A_MCLR,  32'h0000_FFFF, A_MCLR,  32'h0000_0000, 8'd3},  // R3 clear all
    '{A_MSET,  32'h0000_0101, A_MSET,  32'h0000_0101, 8'd2},  // R2 set two
    '{A_MSET,  32'h0000_0000, A_MCLR,  32'h0000_0101, 8'd2},  // R2 zeros keep
    '{A_MSET,  32'hFFFF_0000, A_MSET,  32'h0000_0101, 8'd2},  // R2 upper bits
    '{A_MCLR,  32'h0000_0001, A_MSET,  32'h0000_0100, 8'd3},  // R3 clear one
    '{A_MCLR,  32'h0000_0000, A_MSET,  32'h0000_0100, 8'd3},  // R3 zeros keep
    '{A_EDGE,  32'h0000_A5A5, A_EDGE,  32'h0000_A5A5, 8'd4},  // R4 readback
    '{A_DIR,   32'h0000_00FF, A_DIR,   32'h0000_00FF, 8'd9},  // R9 readback
    '{A_ROUTE, 32'hFFFF_FFFF, A_ROUTE, 32'h0000_8000, 8'd8},  // R8 one bit
    '{A_ROUTE, 32'h0000_0000, A_ROUTE, 32'h0000_0000, 8'd8},  // R8 off
    '{A_HOLE,  32'h0000_1234, A_HOLE,  32'h0000_0000, 8'd10}, // R10 hole
    '{A_STAT,  32'h0000_FFFF, A_STAT,  32'h0000_0000, 8'd6}   // R6 empty clear
  };

  logic        clk_i = 1'b0;
  logic        rst_n_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [11:0] reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic [15:0] pin_i = '0;
  logic [15:0] pin_oe_o;
  logic        irq0_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk_i = ~clk_i;

  gpio_irq_ctrl uut (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_i),
    .reg_we_i    (reg_we_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .pin_i       (pin_i),
    .pin_oe_o    (pin_oe_o),
    .irq0_o      (irq0_o)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk_i);
    reg_we_i    = 1'b1;
    reg_addr_i  = a;
    reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i    = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] exp, input string req);
    @(negedge clk_i);
    reg_addr_i = a;
    #1;
    check(reg_rdata_o, exp, req);
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic reset_state(input string req);
    rd(A_DIR,   32'h0000_FFFF, req);
    rd(A_MSET,  32'h0000_FFFF, req);
    rd(A_EDGE,  32'h0000_0000, req);
    rd(A_STAT,  32'h0000_0000, req);
    rd(A_ROUTE, 32'h0000_0000, req);
    check({31'd0, irq0_o}, 32'd0, req);
    check({16'd0, pin_oe_o}, 32'd0, req);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    settle(3);
    reset_state("R1 in reset");
    rst_n_i = 1'b1;
    settle(4);
    reset_state("R1 after release");

    // Register table walk
    for (int i = 0; i < NVEC; i++) begin
      wr(VECS[i].waddr, VECS[i].wdata);
      rd(VECS[i].raddr, VECS[i].expect_val, $sformatf("R%0d vec%0d", VECS[i].req, i));
    end
    check({16'd0, pin_oe_o}, 32'h0000_FF00, "R9 oe from dir");

    // Restore: all inputs, unmasked, falling, routed
    wr(A_DIR,   32'h0000_FFFF);
    wr(A_EDGE,  32'h0000_0008);
    wr(A_MCLR,  32'h0000_FFFF);
    wr(A_ROUTE, 32'h0000_8000);
    rd(A_HOLE,  32'h0000_0000, "R10 hole write ignored");
    settle(2);

    // R5 rising edge latency on pin 3
    pin_i[3] = 1'b1;
    @(posedge clk_i);
    @(posedge clk_i);
    rd(A_STAT, 32'h0, "R5 not yet after two edges");
    check({31'd0, irq0_o}, 32'd0, "R8 irq low before status");
    @(posedge clk_i);
    rd(A_STAT, 32'h8, "R5 set after third edge");
    check({31'd0, irq0_o}, 32'd1, "R8 irq high");

    // R6 sticky and write-one-to-clear; R4 falling not selected on pin 3
    pin_i[3] = 1'b0;
    settle(5);
    rd(A_STAT, 32'h8, "R6 sticky after pin drop");
    wr(A_STAT, 32'h0000_0004);
    rd(A_STAT, 32'h8, "R6 zero bits keep");
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, 32'h0, "R6 cleared");
    check({31'd0, irq0_o}, 32'd0, "R8 irq low after clear");

    // R4 falling edge on pin 4
    pin_i[4] = 1'b1;
    settle(5);
    rd(A_STAT, 32'h0, "R4 rising ignored on falling pin");
    pin_i[4] = 1'b0;
    settle(5);
    rd(A_STAT, 32'h10, "R4 falling detected");

    // R11 mask after latch, masked edges
    wr(A_MSET, 32'h0000_0010);
    rd(A_STAT, 32'h10, "R11 status kept when masked");
    check({31'd0, irq0_o}, 32'd0, "R11 masked irq low");
    wr(A_MCLR, 32'h0000_0010);
    check({31'd0, irq0_o}, 32'd1, "R11 unmask irq high");
    wr(A_STAT, 32'h0000_0010);
    wr(A_MSET, 32'h0000_0020);
    pin_i[5] = 1'b1;
    settle(5);
    pin_i[5] = 1'b0;
    settle(5);
    rd(A_STAT, 32'h0, "R11 masked pin no status");
    wr(A_MCLR, 32'h0000_0020);

    // R8 routing gate
    wr(A_ROUTE, 32'h0000_0000);
    pin_i[3] = 1'b1;
    settle(5);
    rd(A_STAT, 32'h8, "R8 status while unrouted");
    check({31'd0, irq0_o}, 32'd0, "R8 unrouted irq low");
    wr(A_ROUTE, 32'h0000_8000);
    check({31'd0, irq0_o}, 32'd1, "R8 routed irq high");
    wr(A_ROUTE, 32'h0000_7FFF);
    check({31'd0, irq0_o}, 32'd0, "R8 other bits do not route");
    wr(A_ROUTE, 32'h0000_8000);
    pin_i[3] = 1'b0;
    wr(A_STAT, 32'h0000_0008);
    settle(4);

    // R9 output pin does not latch
    wr(A_DIR, 32'h0000_FFBF);
    check({16'd0, pin_oe_o}, 32'h0000_0040, "R9 oe for output pin");
    pin_i[6] = 1'b1;
    settle(5);
    pin_i[6] = 1'b0;
    settle(5);
    rd(A_STAT, 32'h0, "R9 output pin no status");
    wr(A_DIR, 32'h0000_FFFF);
    check({16'd0, pin_oe_o}, 32'h0, "R9 oe released");

    // R7 set and clear in the same cycle
    pin_i[3] = 1'b1;
    settle(5);
    pin_i[3] = 1'b0;
    settle(5);
    rd(A_STAT, 32'h8, "R7 setup latched");
    @(negedge clk_i);
    pin_i[3] = 1'b1;
    @(posedge clk_i);
    @(posedge clk_i);
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, 32'h8, "R7 event wins over clear");
    wr(A_STAT, 32'h0000_0008);
    rd(A_STAT, 32'h0, "R7 plain clear works");
    pin_i[3] = 1'b0;

    // R1 reset in mid operation
    wr(A_MCLR, 32'h0000_00FF);
    @(negedge clk_i);
    rst_n_i = 1'b0;
    settle(2);
    reset_state("R1 mid-run reset");
    rst_n_i = 1'b1;
    settle(4);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule